// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit holds the stack pointer of a small 8-bit processor core and produces the data-memory address of every byte the core moves to or from its stack. The core raises one of four operation strobes: a data push, a data pop, a call (which also covers interrupt entry) or a return (which also covers return-from-interrupt). For each strobe the unit drives a byte address, a write or read strobe and a flag telling which half of a return address is being moved. It then steps the pointer. The stack grows toward lower addresses. Data operations move the pointer by one. Call and return move it by two, spread over two consecutive cycles.

Software sees the pointer as two byte-wide registers in the core's I/O space, and can read and write each of them. The pointer width is a parameter. Bits above the implemented width always read as zero. Pointer arithmetic wraps within the implemented width. Software must place the pointer above 0x60 before it uses the stack. As a debug aid, the unit flags any decrementing step that leaves the pointer below 0x60.

Top module: `stack_ptr_unit`

## Requirements
- R1: After a synchronous reset, the pointer is 0, both pointer bytes read 0, no stack access strobe is active and busy is low.
- R2: A push writes at the current pointer (stk_addr = SP, stk_we = 1) in the strobe cycle, and the pointer is SP-1 from the next cycle on.
- R3: A pop reads at SP+1 (stk_re = 1) in the strobe cycle, and the pointer is SP+1 from the next cycle on.
- R4: A call writes the return-address low byte at SP (stk_hi_byte = 0) in the strobe cycle, then the high byte at SP-1 (stk_hi_byte = 1) in the following cycle, with busy high. The pointer ends at SP-2.
- R5: A return reads the high byte at SP+1 (stk_hi_byte = 1) in the strobe cycle, then the low byte at SP+2 (stk_hi_byte = 0) in the following cycle, with busy high. The pointer ends at SP+2.
- R6: All operation strobes are ignored in the second cycle of a call or return.
- R7: When several strobes are raised together outside a busy cycle, a call wins, then a return, then a push, then a pop.
- R8: I/O address 0x3D reads and writes pointer bits 7:0, and 0x3E reads and writes the bits above 7. A read at any other address returns 0, and a write to any other address leaves the pointer unchanged.
- R9: Pointer bits at or above SP_W (default 10) read as 0 and cannot be set. The pointer wraps modulo 2^SP_W.
- R10: below_floor is high exactly in a cycle whose decrementing step (push or either call cycle) leaves the pointer below 0x60.
- R11: A memory write strobe and a memory read strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_push | input | 1 | Data push strobe |
| op_pop | input | 1 | Data pop strobe |
| op_call | input | 1 | Call / interrupt entry strobe |
| op_ret | input | 1 | Return / return-from-interrupt strobe |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | I/O write enable |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr |
| stk_addr | output | 16 | Data-memory byte address of the stack access |
| stk_we | output | 1 | Stack byte write strobe |
| stk_re | output | 1 | Stack byte read strobe |
| stk_hi_byte | output | 1 | Return-address byte select, 1 for the high byte |
| stk_busy | output | 1 | Second cycle of a call or return |
| below_floor | output | 1 | Decrementing step left the pointer below 0x60 |

## Verification
The bench aims first at the asymmetry between write-then-decrement and increment-then-read. A design that swapped the two would pop from the slot below the last push, and every pop address would be off by one. It drives calls and returns next to each other and raises strobes during the second cycle. A sequencer that accepted those strobes would drift the pointer or swap the byte order. It steers the pointer onto the 0x60 floor, onto zero and onto the all-ones value. Those steps catch a floor comparison that is off by one, and wrap arithmetic that leaks into the bits above the implemented width. It also writes the high byte with all ones set, to expose unimplemented bits that read back as nonzero.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam logic [ADDR_W-1:0] STACK_FLOOR = 16'h0060;

    // one stack step per cycle
    typedef enum logic [2:0] {
        ST_NONE,
        ST_PUSH,
        ST_POP,
        ST_CALL_LO,
        ST_CALL_HI,
        ST_RET_HI,
        ST_RET_LO
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CALL2,
        PH_RET2
    } phase_e;

    typedef struct packed {
        logic dec;   // pointer steps down after this cycle
        logic inc;   // pointer steps up after this cycle
        logic wr;    // memory write at current pointer
        logic rd;    // memory read
        logic pre;   // address is pointer plus one
        logic hi;    // return-address high byte
    } step_ctl_t;

    function automatic step_ctl_t step_ctl(input step_e s);
        step_ctl_t c;
        c = '0;
        case (s)
            ST_PUSH:    begin c.dec = 1'b1; c.wr = 1'b1; end
            ST_POP:     begin c.inc = 1'b1; c.rd = 1'b1; c.pre = 1'b1; end
            ST_CALL_LO: begin c.dec = 1'b1; c.wr = 1'b1; end
            ST_CALL_HI: begin c.dec = 1'b1; c.wr = 1'b1; c.hi = 1'b1; end
            ST_RET_HI:  begin c.inc = 1'b1; c.rd = 1'b1; c.pre = 1'b1; c.hi = 1'b1; end
            ST_RET_LO:  begin c.inc = 1'b1; c.rd = 1'b1; c.pre = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  logic  call,
    input  logic  ret,
    output step_e step,
    output logic  busy
);

    phase_e phase_q, phase_d;

    always_comb begin
        step    = ST_NONE;
        phase_d = PH_IDLE;
        case (phase_q)
            PH_CALL2: step = ST_CALL_HI;
            PH_RET2:  step = ST_RET_LO;
            default: begin
                if (call) begin
                    step    = ST_CALL_LO;
                    phase_d = PH_CALL2;
                end else if (ret) begin
                    step    = ST_RET_HI;
                    phase_d = PH_RET2;
                end else if (push) begin
                    step = ST_PUSH;
                end else if (pop) begin
                    step = ST_POP;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign busy = (phase_q != PH_IDLE);

    // R4: call strobe while idle is followed by the high-byte write
    a_r4_call_second: assert property (@(posedge clk) disable iff (rst)
        (!busy && call) |=> (busy && step == ST_CALL_HI));

    // R5: return strobe while idle is followed by the low-byte read
    a_r5_ret_second: assert property (@(posedge clk) disable iff (rst)
        (!busy && !call && ret) |=> (busy && step == ST_RET_LO));

    // R6: the second cycle never starts another two-cycle operation
    a_r6_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

endmodule

// File: rtl/sp_reg.sv
module sp_reg
    import sp_pkg::*;
#(
    parameter int unsigned SP_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  step_ctl_t       ctl,
    input  logic            io_we,
    input  logic            lo_hit,
    input  logic            hi_hit,
    input  logic [7:0]      io_wdata,
    output logic [SP_W-1:0] sp_q
);

    localparam int unsigned HI_W = SP_W - 8;

    logic [SP_W-1:0] sp_d;
    logic            io_touch;

    assign io_touch = io_we && (lo_hit || hi_hit);

    // software write takes precedence over a stack step
    always_comb begin
        sp_d = sp_q;
        if (io_we && lo_hit)
            sp_d[7:0] = io_wdata;
        else if (io_we && hi_hit)
            sp_d[SP_W-1:8] = io_wdata[HI_W-1:0];
        else if (ctl.dec)
            sp_d = sp_q - 1'b1;
        else if (ctl.inc)
            sp_d = sp_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_d;
    end

    // R2: decrementing step lowers the pointer by one
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctl.dec && !io_touch) |=> (sp_q == SP_W'($past(sp_q) - 1'b1)));

    // R3: incrementing step raises the pointer by one
    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !io_touch) |=> (sp_q == SP_W'($past(sp_q) + 1'b1)));

    // R8: low-byte write lands and leaves upper bits alone
    a_r8_lo_write: assert property (@(posedge clk) disable iff (rst)
        (io_we && lo_hit) |=> (sp_q[7:0] == $past(io_wdata) &&
                               sp_q[SP_W-1:8] == $past(sp_q[SP_W-1:8])));

    // R8: a write outside the pointer bytes with no step keeps the pointer
    a_r8_other_write: assert property (@(posedge clk) disable iff (rst)
        (!io_touch && !ctl.dec && !ctl.inc) |=> $stable(sp_q));

endmodule

// File: rtl/sp_io.sv
module sp_io #(
    parameter int unsigned SP_W    = 10,
    parameter int unsigned IO_AW   = 6,
    parameter logic [IO_AW-1:0] LO_ADDR = 6'h3D,
    parameter logic [IO_AW-1:0] HI_ADDR = 6'h3E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [SP_W-1:0]  sp_q,
    output logic             lo_hit,
    output logic             hi_hit,
    output logic [7:0]       rdata
);

    localparam int unsigned HI_W = SP_W - 8;

    assign lo_hit = (io_addr == LO_ADDR);
    assign hi_hit = (io_addr == HI_ADDR);

    always_comb begin
        rdata = 8'h00;
        if (lo_hit)      rdata = sp_q[7:0];
        else if (hi_hit) rdata = 8'(sp_q[SP_W-1:8]);
    end

    // R9: bits beyond the implemented width read as zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        hi_hit |-> ((16'(rdata) >> HI_W) == 16'h0000));

    // R8: unmapped addresses read zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!lo_hit && !hi_hit) |-> (rdata == 8'h00));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import sp_pkg::*;
#(
    parameter int unsigned SP_W  = 10,
    parameter int unsigned IO_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_push,
    input  logic              op_pop,
    input  logic              op_call,
    input  logic              op_ret,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_we,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [ADDR_W-1:0] stk_addr,
    output logic              stk_we,
    output logic              stk_re,
    output logic              stk_hi_byte,
    output logic              stk_busy,
    output logic              below_floor
);

    // SP_W is meant to lie between 9 and 16

    step_e           step;
    step_ctl_t       ctl;
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_up;
    logic [SP_W-1:0] sp_dn;
    logic            lo_hit, hi_hit;

    sp_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .push (op_push),
        .pop  (op_pop),
        .call (op_call),
        .ret  (op_ret),
        .step (step),
        .busy (stk_busy)
    );

    assign ctl = step_ctl(step);

    sp_io #(.SP_W(SP_W), .IO_AW(IO_AW)) u_io (
        .clk     (clk),
        .rst     (rst),
        .io_addr (io_addr),
        .sp_q    (sp_q),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .rdata   (io_rdata)
    );

    sp_reg #(.SP_W(SP_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .io_we    (io_we),
        .lo_hit   (lo_hit),
        .hi_hit   (hi_hit),
        .io_wdata (io_wdata),
        .sp_q     (sp_q)
    );

    assign sp_up       = sp_q + 1'b1;
    assign sp_dn       = sp_q - 1'b1;
    assign stk_addr    = ADDR_W'(ctl.pre ? sp_up : sp_q);
    assign stk_we      = ctl.wr;
    assign stk_re      = ctl.rd;
    assign stk_hi_byte = ctl.hi;
    assign below_floor = ctl.dec && (ADDR_W'(sp_dn) < STACK_FLOOR);

    // R11: never read and write in one cycle
    a_r11_excl: assert property (@(posedge clk) disable iff (rst)
        !(stk_we && stk_re));

    // R10: the floor flag only accompanies a write step
    a_r10_floor_on_write: assert property (@(posedge clk) disable iff (rst)
        below_floor |-> stk_we);

    // R4: the high-byte write of a call sits one below the low-byte write
    a_r4_call_addr: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !stk_hi_byte && !stk_busy && op_call) |=>
            (stk_addr == ADDR_W'(SP_W'($past(stk_addr) - 1'b1))));

endmodule

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;

    localparam int SPW  = 10;
    localparam int MASK = (1 << SPW) - 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_push, op_pop, op_call, op_ret;
    logic [5:0]  io_addr;
    logic        io_we;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [15:0] stk_addr;
    logic        stk_we, stk_re, stk_hi_byte, stk_busy, below_floor;

    int n_chk  = 0;
    int n_fail = 0;
    int m_sp   = 0;
    int m_ph   = 0;   // 0 idle, 1 call second, 2 return second
    bit done   = 0;

    always #2 clk = ~clk;

    stack_ptr_unit #(.SP_W(SPW), .IO_AW(6)) u_stack_ptr_unit (
        .clk(clk), .rst(rst),
        .op_push(op_push), .op_pop(op_pop), .op_call(op_call), .op_ret(op_ret),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .stk_addr(stk_addr), .stk_we(stk_we), .stk_re(stk_re),
        .stk_hi_byte(stk_hi_byte), .stk_busy(stk_busy), .below_floor(below_floor)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int a, input int sp);
        if (a == 'h3D) return sp & 'hFF;
        if (a == 'h3E) return (sp >> 8) & 'hFF;
        return 0;
    endfunction

    // step code: 0 none, 1 push, 2 pop, 3 call lo, 4 call hi, 5 ret hi, 6 ret lo
    function automatic int exp_step(input int ph, input bit pu, input bit po,
                                    input bit ca, input bit re);
        if (ph == 1) return 4;
        if (ph == 2) return 6;
        if (ca) return 3;
        if (re) return 5;
        if (pu) return 1;
        if (po) return 2;
        return 0;
    endfunction

    task automatic cyc(input bit pu, input bit po, input bit ca, input bit re,
                       input bit we, input int a, input int d, input string preq);
        int    st, ea, nsp;
        bit    ewe, ere, ehi, efl, dec, inc;
        string req;
        @(negedge clk);
        op_push = pu; op_pop = po; op_call = ca; op_ret = re;
        io_we = we; io_addr = 6'(a); io_wdata = 8'(d);
        #1;
        st  = exp_step(m_ph, pu, po, ca, re);
        dec = (st == 1 || st == 3 || st == 4);
        inc = (st == 2 || st == 5 || st == 6);
        ewe = dec;
        ere = inc;
        ehi = (st == 4 || st == 5);
        ea  = inc ? ((m_sp + 1) & MASK) : m_sp;
        efl = dec && (((m_sp - 1) & MASK) < 'h60);
        case (st)
            1: req = "R2";
            2: req = "R3";
            3, 4: req = "R4";
            5, 6: req = "R5";
            default: req = "R11";
        endcase
        if (preq != "") req = preq;
        chk(req, "stk_we", int'(stk_we), int'(ewe));
        chk(req, "stk_re", int'(stk_re), int'(ere));
        if (ewe || ere) begin
            chk(req, "stk_addr", int'(stk_addr), ea);
            chk(req, "stk_hi_byte", int'(stk_hi_byte), int'(ehi));
        end
        chk("R6", "stk_busy", int'(stk_busy), int'(m_ph != 0));
        chk("R10", "below_floor", int'(below_floor), int'(efl));
        chk((a == 'h3E) ? "R9" : "R8", "io_rdata", int'(io_rdata), exp_rdata(a, m_sp));
        @(posedge clk);
        nsp = m_sp;
        if (we && a == 'h3D)      nsp = (m_sp & ~'hFF) | (d & 'hFF);
        else if (we && a == 'h3E) nsp = (m_sp & 'hFF) | ((d << 8) & MASK & ~'hFF);
        else if (dec)             nsp = (m_sp - 1) & MASK;
        else if (inc)             nsp = (m_sp + 1) & MASK;
        m_sp = nsp;
        m_ph = (st == 3) ? 1 : (st == 5) ? 2 : 0;
    endtask

    task automatic set_sp(input int v);
        cyc(0, 0, 0, 0, 1, 'h3D, v & 'hFF, "R8");
        cyc(0, 0, 0, 0, 1, 'h3E, (v >> 8) & 'hFF, "R8");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        op_push = 0; op_pop = 0; op_call = 0; op_ret = 0;
        io_we = 0; io_addr = 6'h3D; io_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "rdata lo", int'(io_rdata), 0);
        chk("R1", "stk_we", int'(stk_we), 0);
        chk("R1", "stk_re", int'(stk_re), 0);
        chk("R1", "stk_busy", int'(stk_busy), 0);
        io_addr = 6'h3E;
        #1;
        chk("R1", "rdata hi", int'(io_rdata), 0);

        // R9: unimplemented high bits
        cyc(0, 0, 0, 0, 1, 'h3E, 'hFF, "R9");
        cyc(0, 0, 0, 0, 0, 'h3E, 0, "R9");
        // R8: other addresses ignored and read zero
        cyc(0, 0, 0, 0, 1, 'h3C, 'h55, "R8");
        cyc(0, 0, 0, 0, 0, 'h3C, 0, "R8");
        cyc(0, 0, 0, 0, 0, 'h3D, 0, "R8");

        // R10: floor crossing
        set_sp('h61);
        cyc(1, 0, 0, 0, 0, 'h3D, 0, "R10");
        cyc(1, 0, 0, 0, 0, 'h3D, 0, "R10");
        cyc(0, 1, 0, 0, 0, 'h3D, 0, "R3");
        // R4/R5: call then return around the floor
        set_sp('h62);
        cyc(0, 0, 1, 0, 0, 'h3D, 0, "R4");
        cyc(1, 1, 1, 1, 0, 'h3D, 0, "R6");
        cyc(0, 0, 0, 1, 0, 'h3D, 0, "R5");
        cyc(0, 0, 1, 1, 0, 'h3E, 0, "R6");
        // R7: priority
        cyc(1, 1, 1, 1, 0, 'h3D, 0, "R7");
        cyc(0, 0, 0, 0, 0, 'h3D, 0, "R7");
        cyc(1, 1, 0, 1, 0, 'h3D, 0, "R7");
        cyc(0, 0, 0, 0, 0, 'h3D, 0, "R7");
        cyc(1, 1, 0, 0, 0, 'h3D, 0, "R7");
        // R9: wrap at zero and at the top
        set_sp(0);
        cyc(1, 0, 0, 0, 0, 'h3E, 0, "R9");
        cyc(0, 0, 0, 0, 0, 'h3E, 0, "R9");
        cyc(0, 1, 0, 0, 0, 'h3D, 0, "R9");
        set_sp(MASK);
        cyc(0, 0, 0, 1, 0, 'h3D, 0, "R9");
        cyc(0, 0, 0, 0, 0, 'h3E, 0, "R9");

        // constrained random mix
        set_sp('h2F0);
        for (int i = 0; i < 3000; i++) begin
            r = $urandom_range(0, 99);
            if (r < 8 && m_ph == 0) begin
                cyc(0, 0, 0, 0, 1, $urandom_range(0, 1) ? 'h3D : 'h3E,
                    $urandom_range(0, 255), "");
            end else begin
                cyc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                    $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, 0,
                    $urandom_range('h3C, 'h3F), 0, "");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule